// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Front End

This block is the host-side register file of a two-channel asynchronous serial controller that also has a shared counter/timer and a parallel output port. A host drives a 4-bit address, separate read and write strobes and an 8-bit write data bus. The block returns read data in the same cycle as the read strobe. It keeps the configuration registers and sends one-cycle request pulses to the channel receivers and transmitters and to the counter. Status, receive data, interrupt status, input-port values and the live counter value come in as inputs and are only multiplexed onto the read bus.

One address decodes differently for a read and for a write. Each channel has two mode registers behind a single address. A sticky per-channel pointer chooses between them. Two read addresses act as counter start and stop commands. The output latch is never written directly: one write address sets bits and another clears them.

Top module: `duart_regfile`

## Requirements
- R1: A read with `rd_en`=1 and `wr_en`=0 returns, in the same cycle, the value for its address. 0/8 give the channel A/B mode register chosen by that channel's pointer, 1/9 `stat_a`/`stat_b`, 3/B `rxd_a`/`rxd_b`. 4 gives `ipcr_in`, 5 `isr_in`, 6 `cnt_val[15:8]` and 7 `cnt_val[7:0]`. C gives the vector register and D `ip_in`. With no read active, `rdata` is 8'h00.
- R2: A write updates one register at the next clock edge. 1/9 load clock select A/B, 4 auxiliary control, 5 interrupt mask, 6 counter upper preload, 7 counter lower preload, C the vector and D the output configuration.
- R3: After reset, each channel's pointer selects mode register 1. Any read or write at that channel's mode address (0 for A, 8 for B) uses the register currently selected and then moves the pointer to mode register 2.
- R4: The pointer stays on mode register 2 until reset, or until a write to that channel's command address (2/A) with data bits [6:4]=3'b001. That code moves the pointer back and produces no command strobe.
- R5: Accesses and commands on one channel never change the other channel's pointer or registers.
- R6: A read at E pulses `cnt_start`, and a read at F pulses `cnt_stop`, for exactly the one cycle after the access edge. The two are never high together.
- R7: A write at E ORs the data into `oplat`. A write at F clears each `oplat` bit whose data bit is 1. Data bits of 0 leave the latch unchanged.
- R8: Any other command write (2/A), a transmit write (3/B) and a receive-buffer read (3/B) each raise the matching per-channel strobe for exactly the cycle after the access edge. Command and transmit strobes carry the written byte.
- R9: A read at the reserved addresses 2 and A returns 8'h00 and changes no register, pointer or strobe.
- R10: While `rst_n` is low at a clock edge, all registers clear to 0 except the vector, which loads 8'h0F. Both pointers select mode register 1 and all strobes are low.
- R11: When `rd_en` and `wr_en` are high together, the write takes effect and the read is ignored: `rdata` is 8'h00 and no read side effect occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 4 | Register address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| stat_a | input | 8 | Channel A status |
| stat_b | input | 8 | Channel B status |
| rxd_a | input | 8 | Channel A receive data |
| rxd_b | input | 8 | Channel B receive data |
| ipcr_in | input | 8 | Input-change register value |
| isr_in | input | 8 | Interrupt status |
| ip_in | input | 8 | Input port pins |
| cnt_val | input | 16 | Current counter value |
| mr1 | output | 2x8 | Mode register 1, index 0 = channel A |
| mr2 | output | 2x8 | Mode register 2 per channel |
| csel | output | 2x8 | Clock select per channel |
| cmd_stb | output | 2 | Command strobe per channel |
| cmd_byte | output | 2x8 | Command byte per channel |
| tx_stb | output | 2 | Transmit-load strobe per channel |
| tx_byte | output | 2x8 | Transmit byte per channel |
| rx_pop | output | 2 | Receive-buffer read strobe per channel |
| auxc | output | 8 | Auxiliary control |
| imask | output | 8 | Interrupt mask |
| ivec | output | 8 | Interrupt vector |
| cnt_hi | output | 8 | Counter upper preload |
| cnt_lo | output | 8 | Counter lower preload |
| opcfg | output | 8 | Output-port configuration |
| oplat | output | 8 | Output latch |
| cnt_start | output | 1 | Counter start pulse |
| cnt_stop | output | 1 | Counter stop pulse |

## Verification
A pointer stuck on the wrong mode register appears on the next mode access. The byte returned from address 0 or 8 comes from the wrong register, and a mode write lands in the wrong `mr1`/`mr2` output one edge later. A latch or strobe error is visible on the ports in the cycle right after the access edge. The bench keeps a reference model of every register and both pointers and compares all outputs after every access. The random mix of reads, writes and overlapped strobes brings cross-channel disturbance to light within a few accesses.

// File: rtl/duart_rf_pkg.sv
// Package: shared widths, address codes and reset values for the
// dual-channel register front end. Assumes a fixed 16-entry address map.
package duart_rf_pkg;
    localparam int DW  = 8;
    localparam int NCH = 2;
    localparam logic [DW-1:0] IVEC_RST = 8'h0F;
    localparam logic [2:0]    CMD_PTR_RST = 3'b001;

    // Offset inside a channel window (addr[1:0] when addr[2] == 0)
    typedef enum logic [1:0] {
        SUB_MODE = 2'd0,
        SUB_SC   = 2'd1,   // status on read, clock select on write
        SUB_RC   = 2'd2,   // reserved on read, command on write
        SUB_BUF  = 2'd3    // receive buffer on read, transmit on write
    } sub_e;

    // Shared addresses
    localparam logic [3:0] A_IPC_AUX = 4'h4;
    localparam logic [3:0] A_ISR_IMR = 4'h5;
    localparam logic [3:0] A_CNT_HI  = 4'h6;
    localparam logic [3:0] A_CNT_LO  = 4'h7;
    localparam logic [3:0] A_VEC     = 4'hC;
    localparam logic [3:0] A_IP_CFG  = 4'hD;
    localparam logic [3:0] A_START   = 4'hE;
    localparam logic [3:0] A_STOP    = 4'hF;
endpackage

// File: rtl/duart_chan_regs.sv
// Per-channel registers: two mode registers behind a sticky pointer,
// clock select, and the command/transmit/receive strobes. Assumes at most
// one decoded access strobe is high in a cycle.
module duart_chan_regs
    import duart_rf_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_rd,
    input  logic          mode_wr,
    input  logic          csel_wr,
    input  logic          cmd_wr,
    input  logic          tx_wr,
    input  logic          rx_rd,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] mode_rdata,
    output logic [DW-1:0] mr1_q,
    output logic [DW-1:0] mr2_q,
    output logic [DW-1:0] csel_q,
    output logic          cmd_stb_q,
    output logic [DW-1:0] cmd_byte_q,
    output logic          tx_stb_q,
    output logic [DW-1:0] tx_byte_q,
    output logic          rx_pop_q
);
    logic ptr_q;     // 0 selects mode register 1, 1 selects mode register 2
    logic ptr_clr;

    // Pointer reset request from the command code
    assign ptr_clr = cmd_wr && (wdata[6:4] == CMD_PTR_RST);

    // Mode read returns the register under the pointer
    assign mode_rdata = ptr_q ? mr2_q : mr1_q;

    // Pointer: advances on any mode access, returns on command or reset
    always_ff @(posedge clk) begin
        if (!rst_n)                 ptr_q <= 1'b0;
        else if (ptr_clr)           ptr_q <= 1'b0;
        else if (mode_rd || mode_wr) ptr_q <= 1'b1;
    end

    // Mode and clock-select registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mr1_q  <= '0;
            mr2_q  <= '0;
            csel_q <= '0;
        end else begin
            if (mode_wr && !ptr_q) mr1_q <= wdata;
            if (mode_wr &&  ptr_q) mr2_q <= wdata;
            if (csel_wr)           csel_q <= wdata;
        end
    end

    // One-cycle strobes toward the channel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_stb_q  <= 1'b0;
            cmd_byte_q <= '0;
            tx_stb_q   <= 1'b0;
            tx_byte_q  <= '0;
            rx_pop_q   <= 1'b0;
        end else begin
            cmd_stb_q <= cmd_wr && !ptr_clr;
            tx_stb_q  <= tx_wr;
            rx_pop_q  <= rx_rd;
            if (cmd_wr && !ptr_clr) cmd_byte_q <= wdata;
            if (tx_wr)              tx_byte_q  <= wdata;
        end
    end

    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_rd || mode_wr) |=> ptr_q); // R3
    AST_PTR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_q && !ptr_clr) |=> ptr_q); // R4
    AST_PTR_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_clr |=> (!ptr_q && !cmd_stb_q)); // R4
    AST_MR1_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && ptr_q) |=> $stable(mr1_q)); // R3
    AST_TX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr |=> (tx_stb_q && tx_byte_q == $past(wdata))); // R8
endmodule

// File: rtl/duart_shared_regs.sv
// Shared registers: auxiliary control, interrupt mask, vector, counter
// preloads, output configuration, set/clear output latch, counter pulses.
// Assumes decoded one-hot write and read strobes from the top.
module duart_shared_regs
    import duart_rf_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          aux_wr,
    input  logic          imask_wr,
    input  logic          hi_wr,
    input  logic          lo_wr,
    input  logic          vec_wr,
    input  logic          cfg_wr,
    input  logic          set_wr,
    input  logic          clr_wr,
    input  logic          start_rd,
    input  logic          stop_rd,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] auxc_q,
    output logic [DW-1:0] imask_q,
    output logic [DW-1:0] ivec_q,
    output logic [DW-1:0] cnt_hi_q,
    output logic [DW-1:0] cnt_lo_q,
    output logic [DW-1:0] opcfg_q,
    output logic [DW-1:0] oplat_q,
    output logic          start_q,
    output logic          stop_q
);
    // Plain configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            auxc_q   <= '0;
            imask_q  <= '0;
            ivec_q   <= IVEC_RST;
            cnt_hi_q <= '0;
            cnt_lo_q <= '0;
            opcfg_q  <= '0;
        end else begin
            if (aux_wr)   auxc_q   <= wdata;
            if (imask_wr) imask_q  <= wdata;
            if (vec_wr)   ivec_q   <= wdata;
            if (hi_wr)    cnt_hi_q <= wdata;
            if (lo_wr)    cnt_lo_q <= wdata;
            if (cfg_wr)   opcfg_q  <= wdata;
        end
    end

    // Output latch changed only by bit-set and bit-clear writes
    always_ff @(posedge clk) begin
        if (!rst_n)      oplat_q <= '0;
        else if (set_wr) oplat_q <= oplat_q | wdata;
        else if (clr_wr) oplat_q <= oplat_q & ~wdata;
    end

    // Counter command pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            stop_q  <= 1'b0;
        end else begin
            start_q <= start_rd;
            stop_q  <= stop_rd;
        end
    end

    AST_OPL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_wr |=> ((oplat_q & $past(wdata)) == $past(wdata)
                    && (oplat_q & ~$past(wdata)) == ($past(oplat_q) & ~$past(wdata)))); // R7
    AST_OPL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((oplat_q & $past(wdata)) == '0
                    && (oplat_q & ~$past(wdata)) == ($past(oplat_q) & ~$past(wdata)))); // R7
    AST_CNT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_q, stop_q})); // R6
    AST_CNT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |=> !start_q || $past(start_rd)); // R6
endmodule

// File: rtl/duart_regfile.sv
// Top: decodes the 4-bit address (differently for read and write), routes
// strobes to the two channel slices and the shared slice, and muxes read
// data. Assumes the host raises rd_en/wr_en for one cycle per access; a
// write overrides a simultaneous read.
module duart_regfile
    import duart_rf_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [3:0]          addr,
    input  logic                rd_en,
    input  logic                wr_en,
    input  logic [7:0]          wdata,
    output logic [7:0]          rdata,
    input  logic [7:0]          stat_a,
    input  logic [7:0]          stat_b,
    input  logic [7:0]          rxd_a,
    input  logic [7:0]          rxd_b,
    input  logic [7:0]          ipcr_in,
    input  logic [7:0]          isr_in,
    input  logic [7:0]          ip_in,
    input  logic [15:0]         cnt_val,
    output logic [1:0][7:0]     mr1,
    output logic [1:0][7:0]     mr2,
    output logic [1:0][7:0]     csel,
    output logic [1:0]          cmd_stb,
    output logic [1:0][7:0]     cmd_byte,
    output logic [1:0]          tx_stb,
    output logic [1:0][7:0]     tx_byte,
    output logic [1:0]          rx_pop,
    output logic [7:0]          auxc,
    output logic [7:0]          imask,
    output logic [7:0]          ivec,
    output logic [7:0]          cnt_hi,
    output logic [7:0]          cnt_lo,
    output logic [7:0]          opcfg,
    output logic [7:0]          oplat,
    output logic                cnt_start,
    output logic                cnt_stop
);
    logic       rd_act, wr_act, in_chan;
    logic       ch_sel;
    sub_e       sub;
    logic [NCH-1:0][DW-1:0] mode_rdata;
    logic [NCH-1:0][DW-1:0] stat_v, rxd_v;

    assign wr_act  = wr_en;
    assign rd_act  = rd_en && !wr_en;
    assign in_chan = !addr[2];
    assign ch_sel  = addr[3];
    assign sub     = sub_e'(addr[1:0]);
    assign stat_v  = {stat_b, stat_a};
    assign rxd_v   = {rxd_b, rxd_a};

    // Channel slices, one per channel window
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic hit;
        assign hit = in_chan && (ch_sel == c[0]);

        duart_chan_regs u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .mode_rd    (rd_act && hit && sub == SUB_MODE),
            .mode_wr    (wr_act && hit && sub == SUB_MODE),
            .csel_wr    (wr_act && hit && sub == SUB_SC),
            .cmd_wr     (wr_act && hit && sub == SUB_RC),
            .tx_wr      (wr_act && hit && sub == SUB_BUF),
            .rx_rd      (rd_act && hit && sub == SUB_BUF),
            .wdata      (wdata),
            .mode_rdata (mode_rdata[c]),
            .mr1_q      (mr1[c]),
            .mr2_q      (mr2[c]),
            .csel_q     (csel[c]),
            .cmd_stb_q  (cmd_stb[c]),
            .cmd_byte_q (cmd_byte[c]),
            .tx_stb_q   (tx_stb[c]),
            .tx_byte_q  (tx_byte[c]),
            .rx_pop_q   (rx_pop[c])
        );
    end

    // Shared slice
    duart_shared_regs u_sh (
        .clk      (clk),
        .rst_n    (rst_n),
        .aux_wr   (wr_act && addr == A_IPC_AUX),
        .imask_wr (wr_act && addr == A_ISR_IMR),
        .hi_wr    (wr_act && addr == A_CNT_HI),
        .lo_wr    (wr_act && addr == A_CNT_LO),
        .vec_wr   (wr_act && addr == A_VEC),
        .cfg_wr   (wr_act && addr == A_IP_CFG),
        .set_wr   (wr_act && addr == A_START),
        .clr_wr   (wr_act && addr == A_STOP),
        .start_rd (rd_act && addr == A_START),
        .stop_rd  (rd_act && addr == A_STOP),
        .wdata    (wdata),
        .auxc_q   (auxc),
        .imask_q  (imask),
        .ivec_q   (ivec),
        .cnt_hi_q (cnt_hi),
        .cnt_lo_q (cnt_lo),
        .opcfg_q  (opcfg),
        .oplat_q  (oplat),
        .start_q  (cnt_start),
        .stop_q   (cnt_stop)
    );

    // Read-data multiplexer, zero when no read is active
    always_comb begin
        rdata = '0;
        if (rd_act) begin
            if (in_chan) begin
                unique case (sub)
                    SUB_MODE: rdata = mode_rdata[ch_sel];
                    SUB_SC:   rdata = stat_v[ch_sel];
                    SUB_RC:   rdata = '0;
                    SUB_BUF:  rdata = rxd_v[ch_sel];
                endcase
            end else begin
                case (addr)
                    A_IPC_AUX: rdata = ipcr_in;
                    A_ISR_IMR: rdata = isr_in;
                    A_CNT_HI:  rdata = cnt_val[15:8];
                    A_CNT_LO:  rdata = cnt_val[7:0];
                    A_VEC:     rdata = ivec;
                    A_IP_CFG:  rdata = ip_in;
                    default:   rdata = '0;
                endcase
            end
        end
    end

    AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_act |-> rdata == '0); // R11
    AST_RSV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && in_chan && sub == SUB_RC) |=> (cmd_stb == '0 && tx_stb == '0 && rx_pop == '0)); // R9
    AST_CH_ISOLATE: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en || wr_en) && in_chan && ch_sel) |=> $stable(mr1[0]) && $stable(mr2[0]) && $stable(csel[0])); // R5
endmodule

// File: tb/tb_duart_regfile.sv
module tb_duart_regfile;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  addr;
    logic        rd_en, wr_en;
    logic [7:0]  wdata, rdata;
    logic [7:0]  stat_a, stat_b, rxd_a, rxd_b, ipcr_in, isr_in, ip_in;
    logic [15:0] cnt_val;
    logic [1:0][7:0] mr1, mr2, csel, cmd_byte, tx_byte;
    logic [1:0]  cmd_stb, tx_stb, rx_pop;
    logic [7:0]  auxc, imask, ivec, cnt_hi, cnt_lo, opcfg, oplat;
    logic        cnt_start, cnt_stop;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // reference model
    logic [7:0] m_mr1 [2];
    logic [7:0] m_mr2 [2];
    logic       m_ptr [2];
    logic [7:0] m_csel [2];
    logic [7:0] m_aux, m_imask, m_ivec, m_hi, m_lo, m_cfg, m_lat;

    always #(CLK_PERIOD/2) clk = ~clk;

    duart_regfile dut (.*);

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_mr1[c] = 0; m_mr2[c] = 0; m_ptr[c] = 0; m_csel[c] = 0;
        end
        m_aux = 0; m_imask = 0; m_ivec = 8'h0F; m_hi = 0; m_lo = 0; m_cfg = 0; m_lat = 0;
    endtask

    function automatic logic [7:0] exp_rd(input logic [3:0] a);
        int c = a[3];
        if (!a[2]) begin
            case (a[1:0])
                2'd0: return m_ptr[c] ? m_mr2[c] : m_mr1[c];
                2'd1: return c ? stat_b : stat_a;
                2'd2: return 8'h00;
                default: return c ? rxd_b : rxd_a;
            endcase
        end
        case (a)
            4'h4: return ipcr_in;
            4'h5: return isr_in;
            4'h6: return cnt_val[15:8];
            4'h7: return cnt_val[7:0];
            4'hC: return m_ivec;
            4'hD: return ip_in;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk_regs(input string req);
        for (int c = 0; c < 2; c++) begin
            chk(req, "mr1", mr1[c], m_mr1[c]);
            chk(req, "mr2", mr2[c], m_mr2[c]);
            chk(req, "csel", csel[c], m_csel[c]);
        end
        chk(req, "auxc", auxc, m_aux);
        chk(req, "imask", imask, m_imask);
        chk(req, "ivec", ivec, m_ivec);
        chk(req, "cnt_hi", cnt_hi, m_hi);
        chk(req, "cnt_lo", cnt_lo, m_lo);
        chk(req, "opcfg", opcfg, m_cfg);
        chk(req, "oplat R7", oplat, m_lat);
    endtask

    // One access: drive at negedge, check rdata, then outputs after the edge
    task automatic op(input bit w, input bit r, input logic [3:0] a, input logic [7:0] d);
        logic [1:0] e_cmd, e_tx, e_rx;
        logic e_start, e_stop, rdv;
        int c;
        e_cmd = 0; e_tx = 0; e_rx = 0; e_start = 0; e_stop = 0;
        c = a[3];
        @(negedge clk);
        addr = a; wr_en = w; rd_en = r; wdata = d;
        stat_a = 8'($urandom); stat_b = 8'($urandom); rxd_a = 8'($urandom);
        rxd_b = 8'($urandom); ipcr_in = 8'($urandom); isr_in = 8'($urandom);
        ip_in = 8'($urandom); cnt_val = 16'($urandom);
        #1;
        rdv = r && !w;
        if (rdv && a != 4'hE && a != 4'hF)
            chk(a[3:0] == 4'h2 || a == 4'hA ? "R9" : "R1", "rdata", rdata, exp_rd(a));
        if (r && w) chk("R11", "rdata", rdata, 8'h00);
        if (!r && !w) chk("R1", "idle rdata", rdata, 8'h00);
        // update model
        if (w) begin
            if (!a[2]) begin
                case (a[1:0])
                    2'd0: begin if (m_ptr[c]) m_mr2[c] = d; else m_mr1[c] = d; m_ptr[c] = 1; end
                    2'd1: m_csel[c] = d;
                    2'd2: if (d[6:4] == 3'b001) m_ptr[c] = 0; else e_cmd[c] = 1;
                    default: e_tx[c] = 1;
                endcase
            end else begin
                case (a)
                    4'h4: m_aux = d;   4'h5: m_imask = d;
                    4'h6: m_hi = d;    4'h7: m_lo = d;
                    4'hC: m_ivec = d;  4'hD: m_cfg = d;
                    4'hE: m_lat = m_lat | d;
                    default: m_lat = m_lat & ~d;
                endcase
            end
        end else if (r) begin
            if (!a[2] && a[1:0] == 2'd0) m_ptr[c] = 1;
            if (!a[2] && a[1:0] == 2'd3) e_rx[c] = 1;
            if (a == 4'hE) e_start = 1;
            if (a == 4'hF) e_stop = 1;
        end
        @(negedge clk);
        rd_en = 0; wr_en = 0;
        chk("R8", "cmd_stb", cmd_stb, e_cmd);
        chk("R8", "tx_stb", tx_stb, e_tx);
        chk("R8", "rx_pop", rx_pop, e_rx);
        if (e_cmd[c]) chk("R8", "cmd_byte", cmd_byte[c], d);
        if (e_tx[c])  chk("R8", "tx_byte", tx_byte[c], d);
        chk("R6", "cnt_start", cnt_start, e_start);
        chk("R6", "cnt_stop", cnt_stop, e_stop);
        chk_regs("R2");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 0; addr = 0; rd_en = 0; wr_en = 0; wdata = 0;
        stat_a = 0; stat_b = 0; rxd_a = 0; rxd_b = 0; ipcr_in = 0; isr_in = 0; ip_in = 0; cnt_val = 0;
        model_reset();
        repeat (3) @(negedge clk);
        // R10: reset state
        chk_regs("R10");
        chk("R10", "strobes", {cmd_stb, tx_stb, rx_pop, cnt_start, cnt_stop}, 0);
        rst_n = 1;

        // R3: pointer starts on mode 1, advances on write
        op(1, 0, 4'h0, 8'h11);
        op(1, 0, 4'h0, 8'h22);
        op(1, 0, 4'h0, 8'h33);  // R4 sticky: lands in mr2 again
        op(0, 1, 4'h0, 8'h00);
        // R5: channel B still on mode 1
        op(0, 1, 4'h8, 8'h00);  // reads mr1 B then advances
        op(1, 0, 4'h8, 8'h44);
        // R4: reset-pointer on A only, no command strobe
        op(1, 0, 4'h2, 8'h10);
        op(0, 1, 4'h0, 8'h00);
        op(1, 0, 4'h8, 8'h55);  // B still on mode 2 (R5)
        // R8: ordinary command, transmit, receive pop
        op(1, 0, 4'hA, 8'h20);
        op(1, 0, 4'h3, 8'hA5);
        op(0, 1, 4'hB, 8'h00);
        // R9: reserved reads
        op(0, 1, 4'h2, 8'h00);
        op(0, 1, 4'hA, 8'h00);
        // R6: counter commands
        op(0, 1, 4'hE, 8'h00);
        op(0, 1, 4'hF, 8'h00);
        // R7: set and clear latch bits
        op(1, 0, 4'hE, 8'hF0);
        op(1, 0, 4'hE, 8'h0C);
        op(1, 0, 4'hF, 8'h84);
        op(1, 0, 4'hF, 8'h00);
        // R11: overlapped read and write
        op(1, 1, 4'h0, 8'h66);
        op(1, 1, 4'hE, 8'h01);

        // random mix
        for (int i = 0; i < 400; i++) begin
            int k = $urandom_range(0, 9);
            op(k < 5 || k == 9, k >= 5, 4'($urandom), 8'($urandom));
        end

        // reset again mid-run (R10)
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        model_reset();
        chk_regs("R10");
        op(0, 1, 4'h0, 8'h00);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule